// File: doc/BRIEF.md
# Fibre Channel Frame Receive Filter

This block sits on the receive side of a point-to-point Fibre Channel link, behind the line decoder. Each clock it takes one already-decoded byte, or two at the higher link rate, and each byte comes with a flag that marks a control character. The block finds the ordered sets that open and close a frame and reads the 24-byte header. If the destination identifier or the type in the header differs from the values fixed at build time, the block drops the frame. For a frame that passes this filter, it streams the data-field bytes to a linear memory write port in the order they arrive. At end-of-frame it checks the CRC and raises a one-cycle good or bad pulse.

Frames are never stored whole. A four-byte delay line holds back the most recent bytes of the frame. When the end-of-frame arrives, those four bytes are the received CRC, so they never reach the memory port. The data of a frame that later fails its CRC has already been written. The status pulse is what tells the consumer whether to trust that span of addresses.

Top module: `fc_rx_filter`

## Requirements
- R1: An ordered set starts at a byte with `rx_ctrl` set and value 0xBC and is four bytes long. Its second byte selects the kind: 0x36 is start-of-frame, 0x95 is end-of-frame, and any other value is a fill word. Fill words, an end-of-frame outside a frame, and data bytes outside a frame have no effect on the writes or the status.
- R2: With `wide_mode` low, only `rx_data[7:0]` is taken, one byte per clock. With `wide_mode` high, `rx_data[7:0]` is taken and then `rx_data[15:8]`, and both are processed in that order within the same clock.
- R3: The first 24 frame bytes are the header. The destination identifier is header bytes 1..3, most significant byte first, and the type is header byte 8. If either differs from `MY_DID` or `MY_TYPE`, nothing of the frame is written and no status pulse is given.
- R4: The CRC is CRC-32 with polynomial 0x04C11DB7. Each byte is taken least significant bit first, the register is preset to all ones, and the result is complemented. It covers the header and the data field. The 32-bit value is sent as the four bytes just before end-of-frame, least significant byte first. `frame_good` pulses when the CRC matches.
- R5: An accepted frame whose CRC does not match gives `frame_bad`, and its data bytes are still written.
- R6: Each status pulse lasts one cycle, and at most one pulse is given per frame end. `frame_good` and `frame_bad` are never high together.
- R7: Accepted data bytes are written in arrival order. The address steps by one per byte, starts at 0 after reset and runs on across frames. Header bytes and CRC bytes are never written.
- R8: Each write carries one or two bytes, packed from the low lane upward. `mem_strb` is 01 for one byte and 11 for two. The address is that of the low byte.
- R9: A data field longer than `MAX_PAYLOAD` bytes (2112) has every byte after the limit withheld, and the frame ends with `frame_bad`. A data field of exactly `MAX_PAYLOAD` bytes is valid.
- R10: A start-of-frame inside an open frame that has not been filtered out ends that frame with `frame_bad`, and header capture starts again for the new frame.
- R11: An end-of-frame that arrives before 28 frame bytes (the header plus the CRC) gives `frame_bad`.
- R12: During reset and until the first traffic, `mem_we`, `frame_good` and `frame_bad` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_mode | input | 1 | 1: two bytes per clock, 0: one byte per clock |
| rx_data | input | 16 | Decoded bytes; low lane comes first |
| rx_ctrl | input | 2 | Per-lane control-character flag |
| mem_we | output | 1 | Payload write strobe |
| mem_addr | output | ADDR_W | Byte address of the low byte of the write |
| mem_data | output | 16 | Packed payload bytes |
| mem_strb | output | 2 | Byte lanes valid in this write |
| frame_good | output | 1 | One-cycle pulse: accepted frame ended with a valid CRC |
| frame_bad | output | 1 | One-cycle pulse: accepted frame ended in error |

## Verification
If the delay-line occupancy goes wrong, the damage shows at the first write of the next frame: a byte is shifted or a CRC byte leaks out, and this appears about five byte times after the first data byte. A wrong CRC register or header capture stays hidden until the end-of-frame. There it shows up as a wrong status pulse, or as a frame whose writes are missing altogether. The bench therefore compares every written byte and address against a scoreboard built from the frame generator, and it pairs every status pulse with the verdict the generator predicted.

// File: rtl/fc_rx_pkg.sv
package fc_rx_pkg;

  localparam logic [7:0] K_MARK    = 8'hBC;
  localparam logic [7:0] CODE_SOF  = 8'h36;
  localparam logic [7:0] CODE_EOF  = 8'h95;
  localparam int         HDR_BYTES = 24;
  localparam int         CRC_BYTES = 4;

  // Per-frame parsing context, carried from byte to byte
  typedef struct packed {
    logic [1:0]      os_left;   // ordered-set bytes still to consume
    logic            os_code;   // next ordered-set byte is the code byte
    logic            in_frame;
    logic            drop;      // header did not match
    logic            err;       // data field over the limit
    logic [2:0]      dl_cnt;    // delay-line occupancy
    logic [3:0][7:0] dl;        // dl[0] oldest
    logic [31:0]     crc;
    logic [23:0]     did;
    logic [7:0]      typ;
  } rx_ctx_t;

  // One byte of reflected CRC-32 (polynomial 0x04C11DB7)
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/fc_rx_rst_sync.sv
module fc_rx_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fc_rx_byte_step.sv
module fc_rx_byte_step
  import fc_rx_pkg::*;
#(
  parameter int          MAX_PAYLOAD = 2112,
  parameter int          CNT_W       = 12,
  parameter logic [23:0] MY_DID      = 24'h0A0B0C,
  parameter logic [7:0]  MY_TYPE     = 8'h61
) (
  input  rx_ctx_t          ctx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en,
  input  logic [7:0]       byte_i,
  input  logic             ctrl_i,
  output rx_ctx_t          ctx_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wr,
  output logic [7:0]       wr_byte,
  output logic             good,
  output logic             bad
);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [CNT_W-1:0] DID_HI = CNT_W'(3);
  localparam logic [CNT_W-1:0] TYP_C  = CNT_W'(8);
  localparam logic [CNT_W-1:0] HDR_C  = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] DEC_C  = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(HDR_BYTES + MAX_PAYLOAD);
  localparam logic [CNT_W-1:0] SAT_C  = {CNT_W{1'b1}};

  logic       frame_ok;
  logic [7:0] ex;

  assign frame_ok = (ctx_i.dl_cnt == 3'd4) && (cnt_i >= HDR_C) && !ctx_i.err &&
                    (ctx_i.dl == ~ctx_i.crc);
  assign ex = ctx_i.dl[0];

  always_comb begin
    ctx_o   = ctx_i;
    cnt_o   = cnt_i;
    wr      = 1'b0;
    wr_byte = 8'h00;
    good    = 1'b0;
    bad     = 1'b0;
    if (en) begin
      if (ctrl_i && (byte_i == K_MARK)) begin
        ctx_o.os_left = 2'd3;
        ctx_o.os_code = 1'b1;
      end else if (ctx_i.os_left != 2'd0) begin
        ctx_o.os_left = ctx_i.os_left - 2'd1;
        ctx_o.os_code = 1'b0;
        if (ctx_i.os_code && ((byte_i == CODE_SOF) || (byte_i == CODE_EOF))) begin
          if (ctx_i.in_frame && !ctx_i.drop) begin
            if ((byte_i == CODE_EOF) && frame_ok) good = 1'b1;
            else                                  bad  = 1'b1;
          end
          ctx_o.in_frame = (byte_i == CODE_SOF);
          if (byte_i == CODE_SOF) begin
            ctx_o.dl_cnt = 3'd0;
            ctx_o.crc    = 32'hFFFF_FFFF;
            ctx_o.drop   = 1'b0;
            ctx_o.err    = 1'b0;
            cnt_o        = '0;
          end
        end
      end else if (!ctrl_i && ctx_i.in_frame) begin
        if (ctx_i.dl_cnt == 3'd4) begin
          ctx_o.dl  = {byte_i, ctx_i.dl[3:1]};
          ctx_o.crc = crc_byte(ctx_i.crc, ex);
          if (cnt_i != SAT_C) cnt_o = cnt_i + ONE_C;
          if ((cnt_i >= ONE_C) && (cnt_i <= DID_HI)) ctx_o.did = {ctx_i.did[15:0], ex};
          if (cnt_i == TYP_C) ctx_o.typ = ex;
          if (cnt_i == DEC_C) ctx_o.drop = (ctx_i.did != MY_DID) || (ctx_i.typ != MY_TYPE);
          if ((cnt_i >= HDR_C) && !ctx_i.drop) begin
            if (cnt_i < LIM_C) begin
              wr      = 1'b1;
              wr_byte = ex;
            end else begin
              ctx_o.err = 1'b1;
            end
          end
        end else begin
          ctx_o.dl[ctx_i.dl_cnt[1:0]] = byte_i;
          ctx_o.dl_cnt                = ctx_i.dl_cnt + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/fc_rx_wr_pack.sv
module fc_rx_wr_pack #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lane_wr,
  input  logic [1:0][7:0]   lane_byte,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_data,
  output logic [1:0]        mem_strb
);
  logic [ADDR_W-1:0] next_q, next_d;
  logic              we_d;
  logic [ADDR_W-1:0] addr_d;
  logic [15:0]       data_d;
  logic [1:0]        strb_d;

  always_comb begin
    we_d   = |lane_wr;
    addr_d = mem_addr;
    next_d = next_q;
    data_d = 16'h0000;
    strb_d = 2'b00;
    case (lane_wr)
      2'b11: begin data_d = {lane_byte[1], lane_byte[0]}; strb_d = 2'b11; end
      2'b01: begin data_d = {8'h00, lane_byte[0]};        strb_d = 2'b01; end
      2'b10: begin data_d = {8'h00, lane_byte[1]};        strb_d = 2'b01; end
      default: ;
    endcase
    if (we_d) begin
      addr_d = next_q;
      next_d = next_q + ((lane_wr == 2'b11) ? ADDR_W'(2) : ADDR_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q   <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      mem_strb <= '0;
    end else begin
      next_q   <= next_d;
      mem_we   <= we_d;
      mem_addr <= addr_d;
      mem_data <= data_d;
      mem_strb <= strb_d;
    end
  end
endmodule

// File: rtl/fc_rx_filter.sv
module fc_rx_filter
  import fc_rx_pkg::*;
#(
  parameter int          MAX_PAYLOAD = 2112,
  parameter int          ADDR_W      = 16,
  parameter logic [23:0] MY_DID      = 24'h0A0B0C,
  parameter logic [7:0]  MY_TYPE     = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic [15:0]       rx_data,
  input  logic [1:0]        rx_ctrl,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_data,
  output logic [1:0]        mem_strb,
  output logic              frame_good,
  output logic              frame_bad
);
  localparam int LANES = 2;
  localparam int CNT_W = $clog2(HDR_BYTES + MAX_PAYLOAD + 2);

  logic                  rst_n_s;
  rx_ctx_t               ctx_q;
  logic [CNT_W-1:0]      cnt_q;
  rx_ctx_t               ctx_c [LANES+1];
  logic [CNT_W-1:0]      cnt_c [LANES+1];
  logic [LANES-1:0]      en_l, wr_l, good_l, bad_l;
  logic [LANES-1:0][7:0] wb_l;

  fc_rx_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  assign ctx_c[0] = ctx_q;
  assign cnt_c[0] = cnt_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign en_l[l] = (l == 0) ? 1'b1 : wide_mode;
    fc_rx_byte_step #(
      .MAX_PAYLOAD(MAX_PAYLOAD), .CNT_W(CNT_W), .MY_DID(MY_DID), .MY_TYPE(MY_TYPE)
    ) u_step (
      .ctx_i  (ctx_c[l]),
      .cnt_i  (cnt_c[l]),
      .en     (en_l[l]),
      .byte_i (rx_data[8*l +: 8]),
      .ctrl_i (rx_ctrl[l]),
      .ctx_o  (ctx_c[l+1]),
      .cnt_o  (cnt_c[l+1]),
      .wr     (wr_l[l]),
      .wr_byte(wb_l[l]),
      .good   (good_l[l]),
      .bad    (bad_l[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctx_q      <= '0;
      cnt_q      <= '0;
      frame_good <= 1'b0;
      frame_bad  <= 1'b0;
    end else begin
      ctx_q      <= ctx_c[LANES];
      cnt_q      <= cnt_c[LANES];
      frame_good <= |good_l;
      frame_bad  <= |bad_l;
    end
  end

  fc_rx_wr_pack #(.ADDR_W(ADDR_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lane_wr  (wr_l),
    .lane_byte(wb_l),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .mem_strb (mem_strb)
  );
endmodule

// File: rtl/fc_rx_filter_chk.sv
module fc_rx_filter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wide_mode,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_strb,
  input logic              frame_good,
  input logic              frame_bad
);
  logic [ADDR_W-1:0] addr_exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_exp_q <= '0;
    else if (mem_we) addr_exp_q <= mem_addr + ((mem_strb == 2'b11) ? ADDR_W'(2) : ADDR_W'(1));
  end

  // R6
  dual_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_good && frame_bad));

  // R6
  good_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_good || frame_bad) |=> !(frame_good || frame_bad));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == addr_exp_q));

  // R8
  strb_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_strb == 2'b01) || (mem_strb == 2'b11)));

  // R2
  narrow_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(wide_mode)) |-> (mem_strb == 2'b01));
endmodule

bind fc_rx_filter fc_rx_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_strb(mem_strb), .frame_good(frame_good), .frame_bad(frame_bad)
);

// File: tb/fc_rx_filter_bench.sv
module fc_rx_filter_bench;
  localparam int          MAXP    = 2112;
  localparam logic [23:0] MY_DID  = 24'h0A0B0C;
  localparam logic [7:0]  MY_TYPE = 8'h61;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic [15:0] rx_data = 16'h0;
  logic [1:0]  rx_ctrl = 2'b00;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_data;
  logic [1:0]  mem_strb;
  logic        frame_good, frame_bad;

  always #2 clk = ~clk;

  fc_rx_filter u_fc_rx_filter (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .mem_strb(mem_strb),
    .frame_good(frame_good), .frame_bad(frame_bad)
  );

  logic [8:0] strm[$];
  logic [7:0] exp_b[$];
  string      exp_btag[$];
  logic       exp_s[$];
  string      exp_stag[$];
  int         errs = 0, checks = 0;
  int         n_wr = 0, n_st = 0, n_pair = 0;
  logic [15:0] exp_addr = 16'h0;
  bit         mon_on = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[31] ^ b[i];
      c  = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic void put_os(input logic [7:0] code);
    strm.push_back({1'b1, 8'hBC});
    strm.push_back({1'b0, code});
    strm.push_back({1'b0, 8'hAA});
    strm.push_back({1'b0, 8'h55});
  endfunction

  function automatic void put_d(input logic [7:0] b);
    strm.push_back({1'b0, b});
  endfunction

  // kind: 0 good, 1 corrupted CRC, 2 cut off before CRC (next SOF closes it)
  function automatic void send_frame(input logic [23:0] did, input logic [7:0] typ,
                                     input int plen, input int kind, input string tag);
    logic [31:0] c, r, fcs;
    logic [7:0]  hb;
    bit          match;
    c     = 32'hFFFF_FFFF;
    match = (did == MY_DID) && (typ == MY_TYPE);
    put_os(8'h36);
    for (int i = 0; i < 24; i++) begin
      if (i == 0)               hb = 8'h22;
      else if (i >= 1 && i <= 3) hb = did[8*(3-i) +: 8];
      else if (i == 8)          hb = typ;
      else                      hb = 8'(i * 13 + 5);
      put_d(hb);
      c = crc_step(c, hb);
    end
    for (int k = 0; k < plen; k++) begin
      hb = 8'(k * 29 + plen * 3 + 1);
      put_d(hb);
      c = crc_step(c, hb);
      if (match && (((kind != 2) && (k < MAXP)) || ((kind == 2) && (k < plen - 4)))) begin
        exp_b.push_back(hb);
        exp_btag.push_back(tag);
      end
    end
    if (kind != 2) begin
      for (int i = 0; i < 32; i++) r[i] = c[31-i];
      fcs = ~r;
      if (kind == 1) fcs = fcs ^ 32'h0000_0200;
      for (int i = 0; i < 4; i++) put_d(fcs[8*i +: 8]);
      put_os(8'h95);
    end
    if (match) begin
      exp_s.push_back((kind == 0) && (plen <= MAXP));
      exp_stag.push_back(tag);
    end
    put_os(8'h4A);
    put_os(8'h4A);
  endfunction

  task automatic play(input bit wide);
    @(negedge clk);
    wide_mode = wide;
    while (strm.size() != 0) begin
      logic [8:0] a, b;
      a = strm.pop_front();
      b = 9'h000;
      if (wide && strm.size() != 0) b = strm.pop_front();
      rx_data = {b[7:0], a[7:0]};
      rx_ctrl = {b[8], a[8]};
      @(negedge clk);
    end
    rx_data = 16'h0;
    rx_ctrl = 2'b00;
    repeat (8) @(negedge clk);
  endtask

  // Scoreboard on the output ports
  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_we) begin
        chk(mem_addr == exp_addr, "R7", "write address", mem_addr, exp_addr);
        exp_addr = exp_addr + ((mem_strb == 2'b11) ? 16'd2 : 16'd1);
        if (mem_strb == 2'b11) n_pair++;
        for (int i = 0; i < 2; i++) begin
          if (mem_strb[i]) begin
            n_wr++;
            if (exp_b.size() == 0) chk(1'b0, "R7", "unexpected write byte", mem_data[8*i +: 8], 0);
            else begin
              string t;
              logic [7:0] e;
              t = exp_btag.pop_front();
              e = exp_b.pop_front();
              chk(mem_data[8*i +: 8] == e, t, "payload byte", mem_data[8*i +: 8], e);
            end
          end
        end
      end
      if (frame_good || frame_bad) begin
        n_st++;
        if (exp_s.size() == 0) chk(1'b0, "R6", "unexpected status", {frame_good, frame_bad}, 0);
        else begin
          string t;
          logic e;
          t = exp_stag.pop_front();
          e = exp_s.pop_front();
          chk((frame_good == e) && (frame_bad == !e), t, "frame status good/bad",
              {frame_good, frame_bad}, {e, !e});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int w0, s0;
    repeat (4) @(negedge clk);
    // R12: outputs idle in reset
    chk(!mem_we && !frame_good && !frame_bad, "R12", "outputs in reset",
        {mem_we, frame_good, frame_bad}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_we && !frame_good && !frame_bad, "R12", "outputs after reset",
        {mem_we, frame_good, frame_bad}, 0);
    mon_on = 1'b1;

    for (int m = 0; m < 2; m++) begin
      // R4 / R2: sweep of payload lengths, good frames
      for (int p = 0; p < 10; p++) send_frame(MY_DID, MY_TYPE, p, 0, (m == 1) ? "R2" : "R4");
      send_frame(MY_DID, MY_TYPE, 5, 1, "R5");
      play(m[0]);

      // R3: destination and type mismatches
      w0 = n_wr; s0 = n_st;
      send_frame(MY_DID ^ 24'h000100, MY_TYPE, 12, 0, "R3");
      send_frame(MY_DID, MY_TYPE ^ 8'h01, 12, 0, "R3");
      play(m[0]);
      chk(n_wr == w0, "R3", "writes from filtered frames", n_wr - w0, 0);
      chk(n_st == s0, "R3", "status from filtered frames", n_st - s0, 0);

      // R1: fills, stray data and stray EOF outside a frame
      w0 = n_wr; s0 = n_st;
      put_os(8'h4A); put_d(8'h5A); put_d(8'hBC); put_os(8'h95); put_os(8'h4A);
      play(m[0]);
      chk(n_wr == w0, "R1", "writes from idle traffic", n_wr - w0, 0);
      chk(n_st == s0, "R1", "status from idle traffic", n_st - s0, 0);

      // R11: short frame
      put_os(8'h36);
      for (int i = 0; i < 10; i++) put_d(8'(i + 1));
      put_os(8'h95);
      exp_s.push_back(1'b0); exp_stag.push_back("R11");
      // R10: frame cut by a new SOF, then a good frame
      send_frame(MY_DID, MY_TYPE, 10, 2, "R10");
      send_frame(MY_DID, MY_TYPE, 7, 0, "R10");
      play(m[0]);
    end

    // R9: limit boundary and oversize
    send_frame(MY_DID, MY_TYPE, MAXP, 0, "R9");
    send_frame(MY_DID, MY_TYPE, MAXP + 1, 0, "R9");
    play(1'b0);
    send_frame(MY_DID, MY_TYPE, MAXP + 3, 0, "R9");
    play(1'b1);

    chk(exp_b.size() == 0, "R7", "payload bytes never written", exp_b.size(), 0);
    chk(exp_s.size() == 0, "R6", "status pulses missing", exp_s.size(), 0);
    chk(n_pair > 0, "R8", "two-byte writes seen in wide mode", n_pair, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule